// File: doc/BRIEF.md
# Standby One-Shot Conversion Trigger

This block is a write-only command register in a register bank. It starts a single conversion-and-compare pass of a measurement sequencer while that sequencer is parked in standby. A bus write to the register's address starts the pass. The value written is thrown away, so any data works. The register keeps no state that software can see, and a read of it returns zero.

The trigger only acts when the standby input is high. Once accepted, it produces a one-cycle start pulse toward the conversion engine. It then holds a busy flag until the engine reports completion, and after that it is ready for the next trigger. Writes that arrive during a pass, writes while the sequencer runs continuously, and writes to other addresses all leave the block unchanged.

Top module: `os_trigger`

## Requirements
- R1: A write (wr_en_i high) to address TRIG_ADDR (default 8'h0F) while standby_i is high and busy_o is low makes conv_start_o high in the next cycle.
- R2: conv_start_o is never high for two consecutive cycles.
- R3: busy_o goes high in the same cycle as conv_start_o. It stays high until conv_done_i is sampled high, and it is low in the cycle that follows.
- R4: The value on wr_data_i has no effect on conv_start_o or busy_o.
- R5: rd_data_o is zero at all times.
- R6: A write to TRIG_ADDR while standby_i is low produces no start pulse and leaves busy_o unchanged.
- R7: A write to TRIG_ADDR while busy_o is high is dropped. No second pass is queued.
- R8: A write to any address other than TRIG_ADDR produces no start pulse.
- R9: conv_done_i while busy_o is low has no effect on busy_o or conv_start_o.
- R10: After reset, conv_start_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data (discarded) |
| rd_data_o | output | DATA_W | Read data, always zero |
| standby_i | input | 1 | Sequencer is in standby |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_done_i | input | 1 | Conversion engine finished |
| busy_o | output | 1 | One-shot pass in progress |

## Verification
The bench aims at the windows where a wrong design would fire spuriously:
- A write that lands in the same cycle as conv_done_i. A design that queued it would start a second pass.
- A write that arrives a cycle after the start pulse. It must be dropped, not re-pulsed.
- A write while running continuously. A design that lacked the standby gate would start a conversion.
- A completion strobe while idle. A design that toggled busy on it would lose track of its state.

Random data words and neighbouring addresses expose a decoder that compares too few bits or lets the data value matter.

// File: rtl/os_pkg.sv
package os_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/os_addr_dec.sv
module os_addr_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'h0F
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              standby_i,
  output logic              trig_o
);
  logic hit;
  assign hit    = (addr_i == TRIG_ADDR);
  // only a standby-mode write counts as a trigger request
  assign trig_o = wr_en_i & hit & standby_i;
endmodule

// File: rtl/os_seq.sv
module os_seq
  import os_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic conv_done_i,
  output logic conv_start_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;
  logic       start_d, start_q;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (trig_i) begin
        state_d = SEQ_BUSY;
        start_d = 1'b1;
      end
      SEQ_BUSY: if (conv_done_i) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign conv_start_o = start_q;
  assign busy_o       = (state_q == SEQ_BUSY);

  assert_start_on_trig_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !busy_o) |=> conv_start_o);
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  assert_busy_with_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> conv_start_o);
  assert_done_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && conv_done_i) |=> !busy_o);
  assert_no_queue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !conv_done_i) |=> (busy_o && !conv_start_o));
  assert_idle_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !trig_i) |=> (!busy_o && !conv_start_o));
endmodule

// File: rtl/os_trigger.sv
module os_trigger #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              standby_i,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  output logic              busy_o
);
  logic trig;
  logic unused_wdata;

  // written value is an action token only
  assign unused_wdata = ^wr_data_i;
  assign rd_data_o    = '0;

  os_addr_dec #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
  ) u_dec (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .standby_i(standby_i),
    .trig_o   (trig)
  );

  os_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .conv_done_i (conv_done_i),
    .conv_start_o(conv_start_o),
    .busy_o      (busy_o)
  );

  assert_rd_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o == '0));
  assert_cont_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !busy_o) |=> !conv_start_o);
endmodule

// File: tb/os_trigger_tb.sv
module os_trigger_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] TA = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic standby = 1'b1;
  logic start, done = 1'b0, busy;

  int checks = 0, fails = 0;
  bit exp_busy = 1'b0, exp_start = 1'b0;

  always #10 clk = ~clk;

  os_trigger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_ADDR(TA)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .standby_i(standby),
    .conv_start_o(start), .conv_done_i(done), .busy_o(busy));

  function automatic bit f_trig(bit we, logic [ADDR_W-1:0] a, bit sb);
    return we && (a == TA) && sb;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle at negedge, update model at posedge, check after
  task automatic cyc(bit we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, bit sb, bit dn, string req);
    bit t;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; standby = sb; done = dn;
    t = f_trig(we, a, sb);
    @(posedge clk);
    exp_start = t && !exp_busy;
    exp_busy  = exp_busy ? !dn : t;
    #2;
    chk({req, " start"}, start, exp_start);
    chk({req, " busy"}, busy, exp_busy);
    chk("R5 rd_data", rdata, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk("R10 start", start, 0);
    chk("R10 busy", busy, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 1, 0, "R10");
    // R1 standby trigger, R2 single pulse, R3 busy until done
    cyc(1, TA, 8'hA5, 1, 0, "R1");
    cyc(0, 0, 0, 1, 0, "R2");
    cyc(0, 0, 0, 1, 0, "R3 hold");
    // R7 write while busy, also same cycle as done
    cyc(1, TA, 8'h00, 1, 0, "R7");
    cyc(1, TA, 8'hFF, 1, 1, "R7 done");
    cyc(0, 0, 0, 1, 0, "R3 clear");
    // R9 done while idle
    cyc(0, 0, 0, 1, 1, "R9");
    // R6 continuous mode write
    cyc(1, TA, 8'h3C, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, "R6 after");
    // R8 neighbouring addresses
    cyc(1, TA ^ 8'h01, 8'h11, 1, 0, "R8");
    cyc(1, TA ^ 8'h80, 8'h11, 1, 0, "R8");
    // R4 data zero and all ones both trigger
    cyc(1, TA, 8'h00, 1, 0, "R4");
    cyc(0, 0, 0, 1, 1, "R4 done");
    cyc(1, TA, 8'hFF, 1, 0, "R4");
    cyc(0, 0, 0, 1, 1, "R4 done");
    // R6 standby drop mid-pass keeps the pass running
    cyc(1, TA, 8'h5A, 1, 0, "R1");
    cyc(0, 0, 0, 0, 0, "R6 mid");
    cyc(0, 0, 0, 0, 1, "R3 done");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit we = $urandom_range(0, 1);
      bit sb = ($urandom_range(0, 3) != 0);
      bit dn = ($urandom_range(0, 3) == 0);
      logic [ADDR_W-1:0] a = $urandom_range(0, 1) ? TA : ADDR_W'($urandom);
      cyc(we, a, DATA_W'($urandom), sb, dn, "R1/R4/R7 rand");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule